// File: doc/BRIEF.md
# Synchronized Multi-Output PWM Timing Generator

This block produces seven switching waveforms for a power converter. Six of them share one period counter: four drive the primary-side switches and two drive the synchronous rectifiers. A seventh, auxiliary output runs from a second counter with its own period. This lets it run at a different frequency, for example to drive a pre-regulator stage or to serve as a clock reference. For each output, software sets the count at which the output rises and the count at which it falls.

All timing values are written through a simple register port into a shadow copy. None of them reaches the waveforms until software issues a latch command. The whole set is then transferred in a single cycle at the next boundary of the main period. Both counters restart at that moment. The outputs are held low from the command until one full period under the new values has run, so no mixed old/new pattern can appear. A global enable and a per-output enable mask gate the outputs.

Top module: `pwm_timing_gen`

## Requirements
- R1: The main counter counts 0, 1, … P−1 and then returns to 0, where P is the active main period (shadow address 0). With P equal to 0 or 1 the counter stays at 0. The auxiliary counter behaves the same with its own period (shadow address 1).
- R2: Main output i (i = 0..5, pwm_o bit i; bits 0–3 primary, bits 4–5 rectifier) is registered. In the cycle after the counter shows value c, it is high exactly when rise_i ≤ c < fall_i. rise_i is at shadow address 2+2i and fall_i at 3+2i. When rise_i equals fall_i, or exceeds it, the output stays low.
- R3: The auxiliary output (pwm_o bit 6) follows the rule of R2 against the auxiliary counter. Its rise value is at address 14 and its fall value at address 15.
- R4: Writes to addresses 0–15 change only the shadow copy. They have no effect on any output until a latch transfer.
- R5: Writing address 16 with data bit 1 set requests a latch. At the next main period wrap, all shadow values are copied to the active set in the same cycle, and both counters restart at 0.
- R6: From the cycle after the latch command until the first main period wrap after the copy, every output is held low.
- R7: busy_o goes high in the cycle after a latch command and clears by itself in the cycle after the copy.
- R8: A clear out_en bit holds the matching output low. It does not stop either counter.
- R9: While en is low, both counters are held at 0, all outputs are low, and a pending latch waits.
- R10: A write to address 16 with bit 1 clear has no effect. A latch command issued while a reload is in progress is ignored.
- R11: Synchronous reset clears all shadow and active values and both counters, drives all outputs low and clears busy_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Global enable |
| out_en | input | 7 | Per-output enable, bit 6 is the auxiliary output |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 12 | Register write data |
| pwm_o | output | 7 | Switching outputs (0–3 primary, 4–5 rectifier, 6 auxiliary) |
| busy_o | output | 1 | Latch request pending |

## Verification
On every cycle, the assertions check the following. The counter stays below its period. Outputs are low while the reload is in progress, while they are disabled, and when rise equals fall. The pending flag drops right after the copy. An idle controller stays idle without a command. The rest needs the bench's scenarios and its cycle-by-cycle reference model. That covers the exact edge positions under several timings, and the proof that shadow writes leave the outputs untouched. It also covers the restart of both counters at the copy, that repeated or malformed commands are ignored, and that the auxiliary period runs independently.

// File: rtl/pwmgen_pkg.sv
package pwmgen_pkg;
  localparam int DEF_NMAIN = 6;
  localparam int DEF_TW    = 12;
  localparam int DEF_AW    = 5;
  typedef enum logic [1:0] {LS_IDLE, LS_WAIT, LS_BLANK} latch_st_t;
endpackage

// File: rtl/pwm_cnt.sv
module pwm_cnt #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         restart,
  input  logic [W-1:0] period,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  logic [W:0] nxt;
  assign nxt  = {1'b0, cnt} + (W+1)'(1);
  assign wrap = nxt >= {1'b0, period};

  always_ff @(posedge clk) begin
    if (rst || !en)    cnt <= '0;
    else if (restart)  cnt <= '0;
    else if (wrap)     cnt <= '0;
    else               cnt <= nxt[W-1:0];
  end

  // R1: count never reaches the active period value
  a_r1_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0) || (cnt < period));
endmodule

// File: rtl/pwm_edge.sv
module pwm_edge #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         gate,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] rise,
  input  logic [W-1:0] fall,
  output logic         q
);
  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= gate && (cnt >= rise) && (cnt < fall);
  end

  // R2: equal edges give a flat low output
  a_r2_equal_low: assert property (@(posedge clk) disable iff (rst)
    (rise == fall) |=> !q);
  // R8: a gated channel is low on the next cycle
  a_r8_gate_low: assert property (@(posedge clk) disable iff (rst)
    !gate |=> !q);
endmodule

// File: rtl/pwm_regbank.sv
module pwm_regbank
  import pwmgen_pkg::*;
#(
  parameter int NCH = 7,
  parameter int TW  = 12,
  parameter int AW  = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [TW-1:0]           wr_data,
  input  logic                    boundary,
  output logic [TW-1:0]           per_o,
  output logic [TW-1:0]           aper_o,
  output logic [NCH-1:0][TW-1:0]  rise_o,
  output logic [NCH-1:0][TW-1:0]  fall_o,
  output logic                    copy_o,
  output logic                    forced_o,
  output logic                    busy_o
);
  localparam int EDGE_BASE = 2;
  localparam int CTRL_ADDR = EDGE_BASE + 2 * NCH;
  localparam int LATCH_BIT = 1;

  logic [TW-1:0] sh_per, sh_aper, act_per, act_aper;
  logic [TW-1:0] sh_rise [NCH];
  logic [TW-1:0] sh_fall [NCH];
  logic [TW-1:0] act_rise [NCH];
  logic [TW-1:0] act_fall [NCH];
  latch_st_t     state;
  logic [AW-1:0] idx;
  logic          in_edge, cmd;

  assign idx     = wr_addr - AW'(EDGE_BASE);
  assign in_edge = (wr_addr >= AW'(EDGE_BASE)) && (wr_addr < AW'(CTRL_ADDR));
  assign cmd     = wr_en && (wr_addr == AW'(CTRL_ADDR)) && wr_data[LATCH_BIT];
  assign copy_o  = (state == LS_WAIT) && boundary;
  assign forced_o = (state != LS_IDLE);
  assign busy_o  = (state == LS_WAIT);

  // shadow set
  always_ff @(posedge clk) begin
    if (rst) begin
      sh_per  <= '0;
      sh_aper <= '0;
      for (int c = 0; c < NCH; c++) begin
        sh_rise[c] <= '0;
        sh_fall[c] <= '0;
      end
    end else if (wr_en) begin
      if (wr_addr == AW'(0)) sh_per  <= wr_data;
      if (wr_addr == AW'(1)) sh_aper <= wr_data;
      for (int c = 0; c < NCH; c++) begin
        if (in_edge && (idx[AW-1:1] == (AW-1)'(c))) begin
          if (idx[0]) sh_fall[c] <= wr_data;
          else        sh_rise[c] <= wr_data;
        end
      end
    end
  end

  // active set, copied as one
  always_ff @(posedge clk) begin
    if (rst) begin
      act_per  <= '0;
      act_aper <= '0;
      for (int c = 0; c < NCH; c++) begin
        act_rise[c] <= '0;
        act_fall[c] <= '0;
      end
    end else if (copy_o) begin
      act_per  <= sh_per;
      act_aper <= sh_aper;
      for (int c = 0; c < NCH; c++) begin
        act_rise[c] <= sh_rise[c];
        act_fall[c] <= sh_fall[c];
      end
    end
  end

  // latch sequencing
  always_ff @(posedge clk) begin
    if (rst) state <= LS_IDLE;
    else begin
      case (state)
        LS_IDLE:  if (cmd)      state <= LS_WAIT;
        LS_WAIT:  if (boundary) state <= LS_BLANK;
        LS_BLANK: if (boundary) state <= LS_IDLE;
        default:                state <= LS_IDLE;
      endcase
    end
  end

  assign per_o  = act_per;
  assign aper_o = act_aper;
  for (genvar c = 0; c < NCH; c++) begin : g_out
    assign rise_o[c] = act_rise[c];
    assign fall_o[c] = act_fall[c];
  end

  // R7: pending flag drops right after the copy
  a_r7_busy_clears: assert property (@(posedge clk) disable iff (rst)
    ((state == LS_WAIT) && boundary) |=> !busy_o);
  // R6: blank period lasts until the next wrap
  a_r6_blank_holds: assert property (@(posedge clk) disable iff (rst)
    ((state == LS_BLANK) && !boundary) |=> forced_o);
  // R5: active period takes the shadow value at the copy
  a_r5_copy_takes_shadow: assert property (@(posedge clk) disable iff (rst)
    copy_o |=> (act_per == $past(sh_per)));
  // R4: active values frozen without a copy
  a_r4_active_frozen: assert property (@(posedge clk) disable iff (rst)
    !copy_o |=> $stable(act_per) && $stable(act_aper));
  // R10: idle stays idle without a valid command
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
    ((state == LS_IDLE) && !cmd) |=> (state == LS_IDLE));
endmodule

// File: rtl/pwm_timing_gen.sv
module pwm_timing_gen
  import pwmgen_pkg::*;
#(
  parameter int NMAIN = DEF_NMAIN,
  parameter int TW    = DEF_TW,
  parameter int AW    = DEF_AW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic [NMAIN:0]     out_en,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [TW-1:0]      wr_data,
  output logic [NMAIN:0]     pwm_o,
  output logic               busy_o
);
  localparam int NCH = NMAIN + 1;

  logic [TW-1:0]          per, aper, m_cnt, a_cnt;
  logic [NCH-1:0][TW-1:0] rise, fall;
  logic                   m_wrap, a_wrap, copy, forced, boundary;

  assign boundary = en && m_wrap;

  pwm_regbank #(.NCH(NCH), .TW(TW), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .boundary(boundary), .per_o(per), .aper_o(aper), .rise_o(rise),
    .fall_o(fall), .copy_o(copy), .forced_o(forced), .busy_o(busy_o)
  );

  pwm_cnt #(.W(TW)) u_main_cnt (
    .clk(clk), .rst(rst), .en(en), .restart(copy), .period(per),
    .cnt(m_cnt), .wrap(m_wrap)
  );

  pwm_cnt #(.W(TW)) u_aux_cnt (
    .clk(clk), .rst(rst), .en(en), .restart(copy), .period(aper),
    .cnt(a_cnt), .wrap(a_wrap)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [TW-1:0] src;
    if (i < NMAIN) begin : g_main
      assign src = m_cnt;
    end else begin : g_aux
      assign src = a_cnt;
    end
    pwm_edge #(.W(TW)) u_edge (
      .clk(clk), .rst(rst), .gate(en && out_en[i] && !forced),
      .cnt(src), .rise(rise[i]), .fall(fall[i]), .q(pwm_o[i])
    );
  end

  // R6: every output low while a reload is in progress
  a_r6_forced_low: assert property (@(posedge clk) disable iff (rst)
    forced |=> (pwm_o == '0));
  // R9: disabled block is silent and its counter parked
  a_r9_disabled: assert property (@(posedge clk) disable iff (rst)
    !en |=> ((pwm_o == '0) && (m_cnt == '0) && (a_cnt == '0)));
endmodule

// File: tb/tb_pwm_timing_gen.sv
module tb_pwm_timing_gen;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 7;
  localparam int CTRL = 16;
  localparam int WDOG = 100000;

  logic        clk = 1'b0;
  logic        rst;
  logic        en;
  logic [6:0]  out_en;
  logic        wr_en;
  logic [4:0]  wr_addr;
  logic [11:0] wr_data;
  logic [6:0]  pwm_o;
  logic        busy_o;

  pwm_timing_gen dut (
    .clk(clk), .rst(rst), .en(en), .out_en(out_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .pwm_o(pwm_o), .busy_o(busy_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;
  string cur_req = "R11";

  // behavioural reference state
  int sp, sap, ap, aap, cnt, acnt, st, nc, na;
  int sr [NCH];
  int sf [NCH];
  int ar [NCH];
  int af [NCH];
  bit mo [NCH];
  bit wrap, awrap, copy, cmd;
  logic [6:0] exp_out;
  logic       exp_busy;

  always @(posedge clk) begin
    if (rst) begin
      sp = 0; sap = 0; ap = 0; aap = 0; cnt = 0; acnt = 0; st = 0;
      for (int i = 0; i < NCH; i++) begin
        sr[i] = 0; sf[i] = 0; ar[i] = 0; af[i] = 0; mo[i] = 0;
      end
    end else begin
      for (int i = 0; i < NCH; i++) begin
        int c;
        c = (i < 6) ? cnt : acnt;
        mo[i] = en && out_en[i] && (st == 0) && (c >= ar[i]) && (c < af[i]);
      end
      wrap  = (cnt + 1 >= ap);
      awrap = (acnt + 1 >= aap);
      copy  = en && (st == 1) && wrap;
      cmd   = wr_en && (wr_addr == CTRL) && wr_data[1];
      if (!en) nc = 0; else if (copy) nc = 0; else nc = wrap ? 0 : cnt + 1;
      if (!en) na = 0; else if (copy) na = 0; else na = awrap ? 0 : acnt + 1;
      if (st == 0 && cmd) st = 1;
      else if (copy) st = 2;
      else if (st == 2 && en && wrap) st = 0;
      if (copy) begin
        ap = sp; aap = sap;
        for (int i = 0; i < NCH; i++) begin ar[i] = sr[i]; af[i] = sf[i]; end
      end
      if (wr_en) begin
        if (wr_addr == 0) sp = wr_data;
        else if (wr_addr == 1) sap = wr_data;
        else if (wr_addr < CTRL) begin
          if ((wr_addr - 2) % 2 == 1) sf[(wr_addr - 2) / 2] = wr_data;
          else                        sr[(wr_addr - 2) / 2] = wr_data;
        end
      end
      cnt = nc; acnt = na;
    end
    for (int i = 0; i < NCH; i++) exp_out[i] = mo[i];
    exp_busy = (st == 1);
  end

  always @(negedge clk) begin
    vectors++;
    if (pwm_o !== exp_out || busy_o !== exp_busy) begin
      miscompares++;
      $display("FAIL %s cycle %0d: pwm actual=%b expected=%b busy actual=%b expected=%b",
               cur_req, cyc, pwm_o, exp_out, busy_o, exp_busy);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG) begin
      miscompares++;
      $display("FAIL watchdog: actual=%0d cycles expected below %0d", cyc, WDOG);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'(a); wr_data = 12'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 400; k++) begin
      if (!busy_o) break;
      @(negedge clk);
    end
  endtask

  initial begin
    rst = 1'b1; en = 1'b0; out_en = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    run(3);
    rst = 1'b0;
    // R11: reset state
    cur_req = "R11";
    run(3);
    en = 1'b1; out_en = 7'h7F;

    // R5 R6 R7: first programming and latch
    cur_req = "R5/R6/R7";
    wr(0, 10); wr(1, 7);
    wr(2, 2);  wr(3, 6);     // ch0 2..5
    wr(4, 0);  wr(5, 10);    // ch1 whole period
    wr(6, 5);  wr(7, 5);     // ch2 equal edges (R2)
    wr(8, 7);  wr(9, 3);     // ch3 rise after fall (R2)
    wr(10, 1); wr(11, 9);
    wr(12, 0); wr(13, 0);
    wr(14, 1); wr(15, 4);    // aux (R3)
    wr(CTRL, 2);
    wait_idle();
    run(12);
    // R1 R2 R3: steady operation on both periods
    cur_req = "R1/R2/R3";
    run(40);

    // R4: shadow writes alone change nothing
    cur_req = "R4";
    wr(2, 0); wr(3, 9); wr(0, 5); wr(15, 6);
    run(30);

    // R10: control write without latch bit
    cur_req = "R10";
    wr(CTRL, 1);
    run(15);

    // R8: per-output enable mask
    cur_req = "R8";
    out_en = 7'b1010101;
    run(25);
    out_en = 7'h7F;

    // R9: global disable, including a pending latch
    cur_req = "R9";
    en = 1'b0;
    run(8);
    wr(CTRL, 2);
    run(8);
    en = 1'b1;
    wait_idle();
    run(20);

    // R10: repeated command while reload pending is ignored
    cur_req = "R10";
    wr(0, 4); wr(1, 3);
    wr(CTRL, 2);
    wr(CTRL, 2);
    wr(4, 1);
    wait_idle();
    run(20);

    // R1: period of zero parks the main counter
    cur_req = "R1";
    wr(0, 0); wr(2, 0); wr(3, 1); wr(4, 0); wr(5, 2);
    wr(CTRL, 2);
    wait_idle();
    run(15);

    @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule